// File: doc/BRIEF.md
# External Bus Cycle Controller

This block turns single access requests from a 16-bit processor core into cycles on a multiplexed address/data bus. Each cycle has one address cycle and then a data phase of at least one clock. In the address cycle the byte address is on the shared lines and an address strobe marks it. In the data phase the controller drives the read strobe, or the write strobe together with the write data. A slow device can hold READY low to add wait states. A configurable cap limits how many it can add. One timing mode always adds one extra wait.

Configuration picks the data path width. It can be fixed at 8 bits, fixed at 16 bits, or follow a BUSWIDTH pin that is sampled when the request is accepted. On an 8-bit path a full-word access runs as two byte cycles, low byte first, and the core still sees a single completion. Other configuration inputs choose between these options:

- a latch-pulse or a valid-window address strobe;
- a byte-high-enable pin or a pair of lane-specific write strobes.

The core holds a request until the one-cycle done pulse appears. Read data returns with that pulse.

Top module: `ebc_top`

## Requirements
- R1: After reset and whenever no request is in progress, `rd_n`, `wr_n` and `bhe_n` are 1, `inst` is 0, `ad_oe` is 0 and `rsp_done` is 0. `as_o` sits at its inactive level: 0 when `cfg_adv`=0, 1 when `cfg_adv`=1. `ready` and `buswidth` have no effect in this state.
- R2: A request is accepted at a clock edge where the block is idle, `req_valid` is 1 and `rsp_done` is 0. Each byte cycle is one address cycle followed by 1+W data cycles, where W is that byte cycle's wait count. `rsp_done` is high for exactly one clock, in the clock after the last data cycle. That is N*(2+W)+1 clocks after the accepting edge, with N byte cycles.
- R3: `cfg_width`=11 takes the width from `buswidth` at the accepting edge (0 gives 8 bits, 1 gives 16 bits). `cfg_width`=01 forces 8 bits and `cfg_width`=10 forces 16 bits.
- R4: `cfg_width`=00 is illegal. While it is set, `width_err` is 1 and cycles run as 16-bit. For every other setting `width_err` is 0.
- R5: Waits from READY are counted only after any forced wait. A data cycle is extended while `ready` is 0 and fewer than L such waits have been added. `cfg_wlimit` gives L as follows: 000→0, 001→1, 010→2, 011→3, 100 to 110→3, 111→no limit.
- R6: When `cfg_tmode`=00, the first data cycle of every byte cycle is always followed by one more data cycle, whatever `ready` is. Other `cfg_tmode` values add no forced wait.
- R7: The address cycle drives `ad_out`={`req_addr`,A0} with `ad_oe`=1.
  - On a 16-bit cycle the mask gives the lanes: 01 → A0=0 with BHE=1; 10 → A0=1 with BHE=0; 11 (or 00) → A0=0 with BHE=0. Write data sits on its natural lanes.
  - On an 8-bit cycle BHE is 1. The byte is on `ad_out[7:0]` and address bits 15:8 are on `ad_out[15:8]`.
- R8: On an 8-bit path, mask 11 (or 00) runs two byte cycles back to back, A0=0 then A0=1, with a single `rsp_done`. Masks 01 and 10 run one byte cycle.
- R9: With `cfg_wstrb`=0, `wr_n` goes low for every write data cycle, and `bhe_n` is the active-low BHE during the address and data cycles. With `cfg_wstrb`=1, `wr_n` (low-byte write) goes low in write data cycles of 8-bit cycles and of 16-bit cycles that include lane 0. `bhe_n` (high-byte write) goes low only in write data cycles of 16-bit cycles that include lane 1. Both stay 1 for reads.
- R10: `inst` is 1 through the address and data cycles of a read with `req_fetch`=1, and 0 otherwise.
- R11: With `cfg_adv`=0, `as_o` is 1 in address cycles only. With `cfg_adv`=1, `as_o` is 0 from the address cycle through the last data cycle of each byte cycle.
- R12: `rsp_rdata` holds the bytes read, each in the lane that the mask selects, with unselected lanes 0. On an 8-bit cycle the byte is taken from `ad_in[7:0]`. On a 16-bit cycle it is taken from its own lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one state time per period |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised upstream |
| req_valid | input | 1 | Core request, held until `rsp_done` |
| req_addr | input | DATA_W-1 | Halfword address (byte address bits 15:1) |
| req_wdata | input | DATA_W | Write data, lane 0 in bits 7:0 |
| req_be | input | 2 | Byte mask, bit 0 = lane 0 |
| req_write | input | 1 | 1 write, 0 read |
| req_fetch | input | 1 | Read is an instruction fetch |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data |
| cfg_tmode | input | 2 | Timing mode, 00 forces one wait |
| cfg_width | input | 2 | Bus width policy |
| cfg_wlimit | input | 3 | READY wait limit code |
| cfg_adv | input | 1 | 1 valid-window strobe, 0 latch pulse |
| cfg_wstrb | input | 1 | 1 lane write strobes, 0 BHE + write |
| ad_out | output | DATA_W | Multiplexed address/data drive value |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ad_in | input | DATA_W | Multiplexed bus sample value |
| as_o | output | 1 | Address strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write or low-byte write strobe, active low |
| bhe_n | output | 1 | Byte-high enable or high-byte write, active low |
| inst | output | 1 | Instruction fetch indicator |
| ready | input | 1 | Device ready, low requests waits |
| buswidth | input | 1 | Per-cycle width pin, 1 = 16 bits |
| width_err | output | 1 | Illegal width policy flag |

## Verification
A wrong state or wait count shows up at the end of the affected byte cycle. The data strobe stays low for one clock too many or too few, or the done pulse lands on the wrong clock of the transaction. A wrong lane or split decision shows up one clock after acceptance, as a wrong A0, wrong BHE or wrong write strobe in the address or first data cycle. A wrong split decision also shows as a missing or extra second address cycle. A wrong read-capture lane is seen only in `rsp_rdata` at the done pulse.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } ebc_state_e;

  localparam logic [1:0] WID_PIN = 2'b11;
  localparam logic [1:0] WID_8   = 2'b01;
  localparam logic [1:0] WID_BAD = 2'b00;
  localparam logic [2:0] WLIM_INF = 3'b111;
  localparam logic [1:0] TMODE_FORCED = 2'b00;
endpackage

// File: rtl/ebc_width.sv
module ebc_width
  import ebc_pkg::*;
(
  input  logic [1:0] cfg_width,
  input  logic       pin,
  output logic       wide,
  output logic       illegal
);
  always_comb begin
    case (cfg_width)
      WID_PIN: wide = pin;
      WID_8:   wide = 1'b0;
      default: wide = 1'b1;
    endcase
    illegal = (cfg_width == WID_BAD);
  end
endmodule

// File: rtl/ebc_wait.sv
module ebc_wait
  import ebc_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       step,
  input  logic       force_en,
  input  logic [2:0] lim_code,
  input  logic       ready,
  output logic       stay
);
  logic             forced_q;
  logic [CNT_W-1:0] rw_q;
  logic [CNT_W-1:0] lim_n;
  logic             lim_inf;
  logic             need_force;
  logic             rdy_wait;

  always_comb begin
    lim_inf    = (lim_code == WLIM_INF);
    lim_n      = lim_code[2] ? CNT_W'(3) : CNT_W'(lim_code[1:0]);
    need_force = force_en && !forced_q;
    rdy_wait   = !ready && (lim_inf || (rw_q < lim_n));
    stay       = step && (need_force || rdy_wait);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      forced_q <= 1'b0;
      rw_q     <= '0;
    end else if (clr) begin
      forced_q <= 1'b0;
      rw_q     <= '0;
    end else if (step) begin
      if (need_force) begin
        forced_q <= 1'b1;
      end else if (rdy_wait && (rw_q != {CNT_W{1'b1}})) begin
        rw_q <= rw_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ebc_lane.sv
module ebc_lane #(
  parameter int DATA_W = 16
) (
  input  logic [1:0]        be,
  input  logic              wide,
  input  logic              half,
  input  logic [DATA_W-2:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  output logic              a0,
  output logic              lo_inc,
  output logic              hi_inc,
  output logic              split,
  output logic [DATA_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata
);
  localparam int BYTE_W = DATA_W / 2;

  always_comb begin
    split = !wide && (be == 2'b11);
    if (wide) begin
      a0     = !be[0];
      lo_inc = be[0];
      hi_inc = be[1];
    end else begin
      a0     = split ? half : !be[0];
      lo_inc = !a0;
      hi_inc = a0;
    end
    bus_addr = {waddr, a0};
    if (wide) begin
      bus_wdata = wdata;
    end else begin
      bus_wdata = {bus_addr[DATA_W-1:BYTE_W],
                   a0 ? wdata[DATA_W-1:BYTE_W] : wdata[BYTE_W-1:0]};
    end
  end
endmodule

// File: rtl/ebc_top.sv
module ebc_top
  import ebc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [DATA_W-2:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  input  logic              req_write,
  input  logic              req_fetch,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [1:0]        cfg_tmode,
  input  logic [1:0]        cfg_width,
  input  logic [2:0]        cfg_wlimit,
  input  logic              cfg_adv,
  input  logic              cfg_wstrb,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic              as_o,
  output logic              rd_n,
  output logic              wr_n,
  output logic              bhe_n,
  output logic              inst,
  input  logic              ready,
  input  logic              buswidth,
  output logic              width_err
);
  localparam int BYTE_W = DATA_W / 2;
  localparam int WAIT_W = 2;

  ebc_state_e        st_q, st_d;
  logic [DATA_W-2:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [1:0]        be_q;
  logic              wr_q, fetch_q, wide_q, half_q, done_q;
  logic              take, in_addr, in_data, in_cyc, stay, fin, last_byte;
  logic              wide_now;
  logic              a0, lo_inc, hi_inc, split;
  logic [DATA_W-1:0] bus_addr, bus_wdata;

  ebc_width u_width (
    .cfg_width (cfg_width),
    .pin       (buswidth),
    .wide      (wide_now),
    .illegal   (width_err)
  );

  ebc_lane #(.DATA_W(DATA_W)) u_lane (
    .be        (be_q),
    .wide      (wide_q),
    .half      (half_q),
    .waddr     (addr_q),
    .wdata     (wdata_q),
    .a0        (a0),
    .lo_inc    (lo_inc),
    .hi_inc    (hi_inc),
    .split     (split),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
  );

  ebc_wait #(.CNT_W(WAIT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (in_addr),
    .step     (in_data),
    .force_en (cfg_tmode == TMODE_FORCED),
    .lim_code (cfg_wlimit),
    .ready    (ready),
    .stay     (stay)
  );

  assign in_addr   = (st_q == ST_ADDR);
  assign in_data   = (st_q == ST_DATA);
  assign in_cyc    = in_addr || in_data;
  assign take      = (st_q == ST_IDLE) && req_valid && !done_q;
  assign fin       = in_data && !stay;
  assign last_byte = !split || half_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (take) st_d = ST_ADDR;
      ST_ADDR: st_d = ST_DATA;
      ST_DATA: if (!stay) st_d = last_byte ? ST_IDLE : ST_ADDR;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      half_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin && last_byte;
      if (take) begin
        half_q <= 1'b0;
      end else if (fin && !last_byte) begin
        half_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= (req_be == 2'b00) ? 2'b11 : req_be;
      wr_q    <= req_write;
      fetch_q <= req_fetch;
      wide_q  <= wide_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (take) begin
      rdata_q <= '0;
    end else if (fin && !wr_q) begin
      if (lo_inc) rdata_q[BYTE_W-1:0] <= ad_in[BYTE_W-1:0];
      if (hi_inc) rdata_q[DATA_W-1:BYTE_W] <=
                    wide_q ? ad_in[DATA_W-1:BYTE_W] : ad_in[BYTE_W-1:0];
    end
  end

  always_comb begin
    ad_oe  = in_addr || (in_data && wr_q);
    ad_out = in_addr ? bus_addr : ((in_data && wr_q) ? bus_wdata : '0);
    as_o   = cfg_adv ? !in_cyc : in_addr;
    rd_n   = !(in_data && !wr_q);
    inst   = in_cyc && !wr_q && fetch_q;
    if (cfg_wstrb) begin
      wr_n  = !(in_data && wr_q && (!wide_q || lo_inc));
      bhe_n = !(in_data && wr_q && wide_q && hi_inc);
    end else begin
      wr_n  = !(in_data && wr_q);
      bhe_n = !(in_cyc && wide_q && hi_inc);
    end
  end

  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/ebc_chk.sv
module ebc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       bhe_n,
  input logic       inst,
  input logic       as_o,
  input logic       ad_oe,
  input logic       rsp_done,
  input logic [1:0] cfg_tmode,
  input logic [2:0] cfg_wlimit,
  input logic       cfg_adv,
  input logic       cfg_wstrb
);
  logic       dstb;
  logic [3:0] run_q;
  logic [3:0] run_max;
  logic       lim_inf;

  assign dstb    = !rd_n || !wr_n || (cfg_wstrb && !bhe_n);
  assign lim_inf = (cfg_wlimit == 3'b111);
  assign run_max = 4'((cfg_tmode == 2'b00) ? 1 : 0) +
                   (cfg_wlimit[2] ? 4'd3 : {2'b00, cfg_wlimit[1:0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (dstb) begin
      if (run_q != 4'hF) run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  a_r9_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  a_r2_done_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_done) |-> $past(dstb));
  a_r2_addr_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dstb) |-> $past(ad_oe));
  a_r5_wait_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (dstb && !lim_inf) |-> (run_q <= run_max));
  a_r10_inst_read: assert property (@(posedge clk) disable iff (!rst_n)
    inst |-> (wr_n && (bhe_n || !cfg_wstrb)));
  a_r11_ale_addr_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_adv && as_o) |-> !dstb);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (rd_n && wr_n && bhe_n && !ad_oe));
endmodule

bind ebc_top ebc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .bhe_n      (bhe_n),
  .inst       (inst),
  .as_o       (as_o),
  .ad_oe      (ad_oe),
  .rsp_done   (rsp_done),
  .cfg_tmode  (cfg_tmode),
  .cfg_wlimit (cfg_wlimit),
  .cfg_adv    (cfg_adv),
  .cfg_wstrb  (cfg_wstrb)
);

// File: tb/sim_ebc_top.sv
module sim_ebc_top;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [DW-2:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [1:0]    req_be;
  logic          req_write, req_fetch;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [1:0]    cfg_tmode, cfg_width;
  logic [2:0]    cfg_wlimit;
  logic          cfg_adv, cfg_wstrb;
  logic [DW-1:0] ad_out, ad_in;
  logic          ad_oe, as_o, rd_n, wr_n, bhe_n, inst;
  logic          ready, buswidth, width_err;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mem [0:255];

  always #4 clk = ~clk;

  ebc_top #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_write(req_write),
    .req_fetch(req_fetch), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .cfg_tmode(cfg_tmode), .cfg_width(cfg_width), .cfg_wlimit(cfg_wlimit),
    .cfg_adv(cfg_adv), .cfg_wstrb(cfg_wstrb), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .as_o(as_o), .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n),
    .inst(inst), .ready(ready), .buswidth(buswidth), .width_err(width_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_wide(input logic [1:0] wid, input bit pin);
    if (wid == 2'b11) return pin;
    if (wid == 2'b01) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int exp_lim(input logic [2:0] code, input int k);
    if (code == 3'b111) return k;
    if (code[2]) return 3;
    return int'(code[1:0]);
  endfunction

  task automatic run_txn(input logic [14:0] addr, input logic [15:0] wd,
                         input logic [1:0] be, input bit wr, input bit fetch,
                         input int k, input bit pin);
    bit wide, split, dstb, pdstb, a0e, lo_b, hi_b;
    logic [1:0] bn;
    logic [7:0] ea;
    logic [15:0] exp_rd;
    int nb, f, w, exp_cnt, cnt, b, dc, lim;
    bit got_done;
    wide  = exp_wide(cfg_width, pin);
    bn    = (be == 2'b00) ? 2'b11 : be;
    split = !wide && (bn == 2'b11);
    nb    = split ? 2 : 1;
    f     = (cfg_tmode == 2'b00) ? 1 : 0;
    lim   = exp_lim(cfg_wlimit, k);
    w     = f + ((k < lim) ? k : lim);
    exp_cnt = nb * (2 + w) + 1;
    exp_rd[7:0]  = bn[0] ? mem[{addr[6:0], 1'b0}] : 8'h00;
    exp_rd[15:8] = bn[1] ? mem[{addr[6:0], 1'b1}] : 8'h00;
    chk(width_err == (cfg_width == 2'b00), "R4 width_err", width_err, cfg_width == 2'b00);
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_wdata = wd; req_be = be;
    req_write = wr; req_fetch = fetch; buswidth = pin;
    cnt = 0; b = 0; dc = 0; pdstb = 0; got_done = 0;
    a0e = 0; lo_b = 0; hi_b = 0; ea = 0;
    while (cnt < 64 && !got_done) begin
      @(negedge clk);
      cnt++;
      buswidth = $urandom_range(0, 1);
      dstb = !rd_n || !wr_n || (cfg_wstrb && !bhe_n);
      if (pdstb && !dstb) begin
        chk(dc == 1 + w, "R5 R6 data cycles per byte cycle", dc, 1 + w);
        if (wr) begin
          if (wide) begin
            if (bn[0]) mem[{addr[6:0], 1'b0}] = wd[7:0];
            if (bn[1]) mem[{addr[6:0], 1'b1}] = wd[15:8];
          end else begin
            mem[ea] = a0e ? wd[15:8] : wd[7:0];
          end
        end
        b++;
      end
      if (rsp_done) begin
        got_done = 1;
        chk(cnt == exp_cnt, "R2 done timing", cnt, exp_cnt);
        chk(b == nb, "R8 byte cycle count", b, nb);
        if (!wr) chk(rsp_rdata == exp_rd, "R12 read data", rsp_rdata, exp_rd);
        req_valid = 1'b0;
      end else if (ad_oe && !dstb) begin
        a0e  = wide ? !bn[0] : (split ? b[0] : !bn[0]);
        lo_b = wide ? bn[0] : !a0e;
        hi_b = wide ? bn[1] : a0e;
        ea   = {addr[6:0], a0e};
        chk(ad_out == {addr, a0e}, "R7 R8 address", ad_out, {addr, a0e});
        chk(as_o == !cfg_adv, "R11 strobe in address cycle", as_o, !cfg_adv);
        chk(bhe_n == (cfg_wstrb ? 1'b1 : !(wide && hi_b)), "R7 R9 bhe addr",
            bhe_n, cfg_wstrb ? 1'b1 : !(wide && hi_b));
        chk(inst == (!wr && fetch), "R10 inst", inst, !wr && fetch);
        if (wide) ad_in = {mem[{addr[6:0], 1'b1}], mem[{addr[6:0], 1'b0}]};
        else      ad_in = {~mem[ea], mem[ea]};
        dc = 0;
        ready = $urandom_range(0, 1);
      end else if (dstb) begin
        chk(rd_n == wr, "R9 rd_n", rd_n, wr);
        chk(wr_n == (cfg_wstrb ? !(wr && (!wide || lo_b)) : !wr), "R9 wr_n",
            wr_n, cfg_wstrb ? !(wr && (!wide || lo_b)) : !wr);
        chk(bhe_n == (cfg_wstrb ? !(wr && wide && hi_b) : !(wide && hi_b)),
            "R9 bhe_n data", bhe_n, cfg_wstrb ? !(wr && wide && hi_b) : !(wide && hi_b));
        chk(as_o == 1'b0, "R11 strobe in data cycle", as_o, 0);
        chk(inst == (!wr && fetch), "R10 inst data", inst, !wr && fetch);
        if (wr) begin
          if (wide) begin
            if (bn[0]) chk(ad_out[7:0] == wd[7:0], "R7 low lane data", ad_out[7:0], wd[7:0]);
            if (bn[1]) chk(ad_out[15:8] == wd[15:8], "R7 high lane data", ad_out[15:8], wd[15:8]);
          end else begin
            chk(ad_out == {addr[14:7], a0e ? wd[15:8] : wd[7:0]}, "R7 byte bus data",
                ad_out, {addr[14:7], a0e ? wd[15:8] : wd[7:0]});
          end
        end
        ready = (dc >= f + k);
        dc++;
      end else begin
        ready = $urandom_range(0, 1);
      end
      pdstb = dstb;
    end
    chk(got_done, "R2 done seen", got_done, 1);
    @(negedge clk);
    chk(!rsp_done && rd_n && wr_n && !ad_oe, "R1 R2 quiet after done",
        {rsp_done, rd_n, wr_n, ad_oe}, 4'b0110);
  endtask

  task automatic set_cfg(input logic [1:0] tm, input logic [1:0] wid,
                         input logic [2:0] wl, input bit adv, input bit ws);
    @(negedge clk);
    cfg_tmode = tm; cfg_width = wid; cfg_wlimit = wl; cfg_adv = adv; cfg_wstrb = ws;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    rst_n = 1'b0; req_valid = 0; req_addr = 0; req_wdata = 0; req_be = 2'b11;
    req_write = 0; req_fetch = 0; cfg_tmode = 2'b11; cfg_width = 2'b10;
    cfg_wlimit = 3'b000; cfg_adv = 0; cfg_wstrb = 0; ad_in = 0; ready = 1;
    buswidth = 1;
    repeat (3) @(negedge clk);
    chk(rd_n && wr_n && bhe_n && !inst && !ad_oe && !rsp_done && !as_o,
        "R1 reset state", {rd_n, wr_n, bhe_n, inst, ad_oe, rsp_done, as_o}, 7'b1110000);
    rst_n = 1'b1;
    cfg_adv = 1;
    @(negedge clk);
    chk(as_o == 1'b1, "R1 R11 idle valid-window strobe", as_o, 1);
    for (int i = 0; i < 8; i++) begin
      ready = i[0]; buswidth = i[1];
      @(negedge clk);
      chk(rd_n && wr_n && bhe_n && !ad_oe && !rsp_done, "R1 ready ignored when idle",
          {rd_n, wr_n, bhe_n, ad_oe, rsp_done}, 5'b11100);
    end
    // directed corner cases
    set_cfg(2'b11, 2'b10, 3'b000, 0, 0);
    run_txn(15'h0012, 16'h0000, 2'b11, 0, 0, 0, 1);   // R2 R7 R12 word read
    run_txn(15'h0013, 16'hBEEF, 2'b10, 1, 0, 0, 1);   // R7 high byte write
    run_txn(15'h0013, 16'h0000, 2'b11, 0, 1, 0, 1);   // R10 fetch
    run_txn(15'h0014, 16'h0000, 2'b01, 0, 0, 0, 1);   // R12 low lane only
    set_cfg(2'b11, 2'b01, 3'b000, 0, 0);
    run_txn(15'h0020, 16'hCAFE, 2'b11, 1, 0, 0, 1);   // R3 R8 split write
    run_txn(15'h0020, 16'h0000, 2'b00, 0, 0, 0, 1);   // R8 empty mask as word
    run_txn(15'h0021, 16'h0000, 2'b10, 0, 0, 0, 1);   // R12 8-bit high byte
    set_cfg(2'b11, 2'b11, 3'b000, 0, 0);
    run_txn(15'h0030, 16'h1234, 2'b11, 1, 0, 0, 0);   // R3 pin low
    run_txn(15'h0030, 16'h0000, 2'b11, 0, 0, 0, 1);   // R3 pin high
    set_cfg(2'b11, 2'b00, 3'b000, 0, 0);
    run_txn(15'h0031, 16'h0000, 2'b11, 0, 0, 0, 0);   // R4 illegal -> 16
    set_cfg(2'b01, 2'b10, 3'b010, 0, 0);
    run_txn(15'h0040, 16'h0000, 2'b11, 0, 0, 5, 1);   // R5 limit two
    set_cfg(2'b01, 2'b10, 3'b111, 0, 0);
    run_txn(15'h0041, 16'h0000, 2'b11, 0, 0, 6, 1);   // R5 unlimited
    set_cfg(2'b01, 2'b10, 3'b101, 0, 0);
    run_txn(15'h0042, 16'h0000, 2'b11, 0, 0, 6, 1);   // R5 code 101 as three
    set_cfg(2'b00, 2'b10, 3'b000, 0, 0);
    run_txn(15'h0043, 16'h0000, 2'b11, 0, 0, 0, 1);   // R6 forced wait
    set_cfg(2'b00, 2'b01, 3'b001, 1, 0);
    run_txn(15'h0044, 16'h5A5A, 2'b11, 1, 0, 2, 1);   // R6 R11 forced plus limit
    set_cfg(2'b10, 2'b10, 3'b000, 0, 1);
    run_txn(15'h0050, 16'hA1B2, 2'b01, 1, 0, 0, 1);   // R9 low strobe
    run_txn(15'h0051, 16'hC3D4, 2'b10, 1, 0, 0, 1);   // R9 high strobe
    run_txn(15'h0052, 16'hE5F6, 2'b11, 1, 0, 0, 1);   // R9 both
    run_txn(15'h0050, 16'h0000, 2'b11, 0, 1, 0, 1);   // R9 R10 read in strobe mode
    set_cfg(2'b10, 2'b01, 3'b000, 0, 1);
    run_txn(15'h0053, 16'h7788, 2'b10, 1, 0, 0, 1);   // R9 8-bit odd write
    // random mix
    for (int t = 0; t < 300; t++) begin
      set_cfg(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
              3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)));
      run_txn(15'($urandom_range(0, 32767)), 16'($urandom_range(0, 65535)),
              2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), $urandom_range(0, 5),
              1'($urandom_range(0, 1)));
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule